// File: doc/BRIEF.md
# Flash Operation Status Flag Generator

This block forms the byte a NOR-style flash array hands back when the host reads it while an internal program or erase is running. The command decoder reports the current operation through a mode input. The analog side reports its pulse count and whether the sector-erase acceptance window is still open. The block reports progress through two toggle bits, a timeout flag and an erase-timer flag. When no operation is running, or when the host reads an unsuspended sector during an erase suspend, the block passes the array data through unchanged.

A small controller FSM tracks the operation. It has three states. READY means no operation is tracked. ACTIVE means an operation is running normally. FAILED means the pulse count went over its limit. The transitions are:
- START: READY to ACTIVE, when the mode is not idle.
- TIMEOUT: ACTIVE to FAILED, when the pulse count exceeds `PULSE_LIMIT` in a timed mode.
- DONE: ACTIVE to READY, when the mode returns to idle.
- CLEAR: FAILED to READY, when the mode returns to idle.

On TIMEOUT the controller latches the sector under erase. This lets the second toggle bit keep pointing at the failing sector. Each toggle bit lives in its own flip-flop. A flip-flop inverts at the clock edge of a read strobe only while its own condition holds.

Top module: `flash_status_gen`

## Requirements
- R1: After reset both toggle flip-flops are 0, the FSM is READY, and the status output equals the array data.
- R2: In READY, or with mode code 0 (idle), the status output equals the array data input.
- R3: Status bit 6 inverts after every read in mode 1 (program), mode 2 (sector erase) and mode 4 (suspend-program). In mode 3 (suspend-read) it stays constant.
- R4: One clock after the pulse count exceeds `PULSE_LIMIT` in mode 1, 2 or 4, status bit 5 reads 1. It stays 1 until the mode returns to 0. A count equal to the limit leaves bit 5 at 0.
- R5: After a program has timed out (the lockout case), bit 6 keeps inverting on every read.
- R6: In modes 2, 3 and 4, bit 3 is 0 while the window-open input is 1 and is 1 otherwise. In mode 1, bit 3 is 0.
- R7: In mode 2, bit 2 inverts on reads whose sector matches the erase sector. On reads of other sectors it stays constant.
- R8: In mode 3, a read of the suspended sector returns status, with bit 2 inverting on each read. A read of any other sector returns the array data.
- R9: In mode 4, reads of a sector other than the suspended one return 1 on bit 2. Reads of the suspended sector return the held bit-2 value without inverting it.
- R10: After an erase timeout, bit 2 inverts only on reads of the sector latched at the failure, even if the erase-sector input changes later.
- R11: In every status byte, bits 7, 4, 1 and 0 read 0.
- R12: The sector of an address is its upper `SECT_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb_i | input | 1 | Read strobe, one per host read |
| rd_addr_i | input | ADDR_W | Read address |
| op_mode_i | input | 3 | 0 idle, 1 program, 2 sector erase, 3 suspend-read, 4 suspend-program |
| erase_addr_i | input | ADDR_W | Address inside the sector being erased or suspended |
| pulse_cnt_i | input | CNT_W | Internal pulse count of the running operation |
| win_open_i | input | 1 | Sector-erase acceptance window still open |
| array_data_i | input | 8 | Array data for pass-through reads |
| status_o | output | 8 | Returned read byte |

## Verification
The assertions check the following on every cycle:
- pass-through of array data in READY;
- the window flag on bit 3;
- the forced 1 on bit 2 during suspend-program;
- the zero spare bits;
- that a toggle flip-flop holds when it is not strobed;
- that FAILED is sticky and the failing sector stays latched.

Some behaviour only the bench scenarios can show. This covers how the toggles alternate across a sequence of reads in each mode, and the boundary where the count equals the limit. It also covers bit 2 following the latched failing sector after the erase-sector input has moved, and the return to array data once the mode goes idle.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [2:0] {
        MD_IDLE    = 3'd0,
        MD_PROG    = 3'd1,
        MD_ERASE   = 3'd2,
        MD_SUSP_RD = 3'd3,
        MD_SUSP_PG = 3'd4
    } op_mode_e;

    typedef enum logic [1:0] {
        ST_READY  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_FAILED = 2'd2
    } fsg_state_e;

    function automatic logic is_timed(input logic [2:0] m);
        return (m == MD_PROG) || (m == MD_ERASE) || (m == MD_SUSP_PG);
    endfunction

endpackage

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
    import fsg_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SECT_W      = 4,
    parameter int PULSE_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic [CNT_W-1:0]  pulse_cnt_i,
    input  logic [SECT_W-1:0] erase_sect_i,
    output fsg_state_e        state_o,
    output logic [SECT_W-1:0] fail_sect_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PULSE_LIMIT);

    fsg_state_e        state_q, state_d;
    logic [SECT_W-1:0] fail_q, fail_d;
    logic              over;

    assign over = is_timed(mode_i) && (pulse_cnt_i > LIMIT);

    always_comb begin
        state_d = state_q;
        fail_d  = fail_q;
        unique case (state_q)
            ST_READY: begin
                if (mode_i != MD_IDLE) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (mode_i == MD_IDLE) begin
                    state_d = ST_READY;
                end else if (over) begin
                    state_d = ST_FAILED;
                    fail_d  = erase_sect_i;
                end
            end
            ST_FAILED: begin
                if (mode_i == MD_IDLE) state_d = ST_READY;
            end
            default: state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            fail_q  <= '0;
        end else begin
            state_q <= state_d;
            fail_q  <= fail_d;
        end
    end

    assign state_o     = state_q;
    assign fail_sect_o = fail_q;

    AST_TIMEOUT_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && mode_i != MD_IDLE && over) |=> (state_q == ST_FAILED)); // R4
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAILED && mode_i != MD_IDLE) |=> (state_q == ST_FAILED)); // R4
    AST_FAIL_SECT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAILED && mode_i != MD_IDLE) |=> $stable(fail_q)); // R10

endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic en_i,
    output logic q_o
);

    logic q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                q <= 1'b0;
        else if (strobe_i && en_i) q <= ~q;
    end

    assign q_o = q;

    AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_i && en_i) |=> $stable(q)); // R3
    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && en_i) |=> (q != $past(q))); // R7

endmodule

// File: rtl/fsg_mux.sv
module fsg_mux
    import fsg_pkg::*;
(
    input  fsg_state_e state_i,
    input  logic [2:0] mode_i,
    input  logic       sect_hit_i,
    input  logic       win_open_i,
    input  logic       t6_i,
    input  logic       t2_i,
    input  logic [7:0] array_data_i,
    output logic [7:0] status_o
);

    logic b5, b3, b2;
    logic [7:0] flags;

    always_comb begin
        b5    = (state_i == ST_FAILED);
        b3    = (mode_i != MD_PROG) && !win_open_i;
        b2    = (mode_i == MD_SUSP_PG && !sect_hit_i) ? 1'b1 : t2_i;
        flags = {1'b0, t6_i, b5, 1'b0, b3, b2, 2'b00};
        if (state_i == ST_READY) begin
            status_o = array_data_i;
        end else begin
            unique case (mode_i)
                MD_PROG, MD_ERASE, MD_SUSP_PG: status_o = flags;
                MD_SUSP_RD: status_o = sect_hit_i ? flags : array_data_i;
                default:    status_o = array_data_i;
            endcase
        end
    end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SECT_W      = 4,
    parameter int CNT_W       = 12,
    parameter int PULSE_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [2:0]        op_mode_i,
    input  logic [ADDR_W-1:0] erase_addr_i,
    input  logic [CNT_W-1:0]  pulse_cnt_i,
    input  logic              win_open_i,
    input  logic [7:0]        array_data_i,
    output logic [7:0]        status_o
);

    localparam int SECT_LSB = ADDR_W - SECT_W;

    fsg_state_e        state;
    logic [SECT_W-1:0] rd_sect, er_sect, fail_sect, ref_sect;
    logic              busy, sect_hit, ref_hit, t6_en, t2_en, t6, t2;

    assign rd_sect  = rd_addr_i[ADDR_W-1:SECT_LSB];                    // R12
    assign er_sect  = erase_addr_i[ADDR_W-1:SECT_LSB];
    assign busy     = (state != ST_READY);
    assign sect_hit = (rd_sect == er_sect);
    assign ref_sect = (state == ST_FAILED) ? fail_sect : er_sect;     // R10
    assign ref_hit  = (rd_sect == ref_sect);
    assign t6_en    = busy && is_timed(op_mode_i);
    assign t2_en    = busy && ref_hit &&
                      (op_mode_i == MD_ERASE || op_mode_i == MD_SUSP_RD);

    fsg_ctrl #(
        .CNT_W(CNT_W), .SECT_W(SECT_W), .PULSE_LIMIT(PULSE_LIMIT)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .mode_i(op_mode_i),
        .pulse_cnt_i(pulse_cnt_i), .erase_sect_i(er_sect),
        .state_o(state), .fail_sect_o(fail_sect)
    );

    fsg_toggle tgl6_i (
        .clk(clk), .rst_n(rst_n), .strobe_i(rd_stb_i), .en_i(t6_en), .q_o(t6)
    );

    fsg_toggle tgl2_i (
        .clk(clk), .rst_n(rst_n), .strobe_i(rd_stb_i), .en_i(t2_en), .q_o(t2)
    );

    fsg_mux mux_i (
        .state_i(state), .mode_i(op_mode_i), .sect_hit_i(sect_hit),
        .win_open_i(win_open_i), .t6_i(t6), .t2_i(t2),
        .array_data_i(array_data_i), .status_o(status_o)
    );

    AST_READY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY) |-> (status_o == array_data_i)); // R2
    AST_TIMER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_mode_i == MD_ERASE && win_open_i) |-> !status_o[3]); // R6
    AST_SPG_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_mode_i == MD_SUSP_PG && !sect_hit) |-> status_o[2]); // R9
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_timed(op_mode_i)) |-> (status_o[7] == 1'b0 && status_o[4] == 1'b0 && status_o[1:0] == 2'b00)); // R11

endmodule

// File: tb/flash_status_gen_tb_top.sv
module flash_status_gen_tb_top;

    localparam int ADDR_W = 16;
    localparam int CNT_W  = 12;
    localparam int LIMIT  = 1000;
    localparam logic [7:0] ARR = 8'hA5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_stb = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [2:0]        mode = 3'd0;
    logic [ADDR_W-1:0] er_addr = '0;
    logic [CNT_W-1:0]  pulse = '0;
    logic              win = 1'b0;
    logic [7:0]        arr = ARR;
    logic [7:0]        status;

    int total = 0;
    int bad   = 0;
    logic m6 = 1'b0;
    logic m2 = 1'b0;

    always #2.5 clk = ~clk;

    flash_status_gen #(.ADDR_W(ADDR_W), .SECT_W(4), .CNT_W(CNT_W), .PULSE_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_stb_i(rd_stb), .rd_addr_i(rd_addr),
        .op_mode_i(mode), .erase_addr_i(er_addr), .pulse_cnt_i(pulse),
        .win_open_i(win), .array_data_i(arr), .status_o(status)
    );

    function automatic logic [7:0] st(input logic b6, input logic b5, input logic b3, input logic b2);
        return {1'b0, b6, b5, 1'b0, b3, b2, 2'b00};
    endfunction

    task automatic chk(input string req, input logic [7:0] exp);
        total++;
        if (status !== exp) begin
            bad++;
            $display("FAIL %s: status=%h expected=%h", req, status, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        mode = m;
        @(negedge clk);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string req, input logic [7:0] exp);
        @(negedge clk);
        rd_addr = a;
        rd_stb  = 1'b1;
        #1 chk(req, exp);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic t_reset;
        #1 chk("R1", ARR);
        rd(16'h1234, "R2", ARR);
    endtask

    task automatic t_program;
        set_mode(3'd1);
        for (int i = 0; i < 3; i++) begin
            rd(16'h0100, "R3", st(m6, 1'b0, 1'b0, m2)); m6 = ~m6;
        end
        win = 1'b1;
        pulse = CNT_W'(LIMIT);
        @(negedge clk);
        rd(16'h0100, "R4", st(m6, 1'b0, 1'b0, m2)); m6 = ~m6;
        win = 1'b0;
        pulse = '0;
    endtask

    task automatic t_erase;
        er_addr = 16'h3040;
        win = 1'b1;
        set_mode(3'd2);
        rd(16'h3000, "R6", st(m6, 1'b0, 1'b0, m2)); m6 = ~m6; m2 = ~m2;
        win = 1'b0;
        rd(16'h3FFF, "R7", st(m6, 1'b0, 1'b1, m2)); m6 = ~m6; m2 = ~m2;
        rd(16'h5000, "R7", st(m6, 1'b0, 1'b1, m2)); m6 = ~m6;
        rd(16'h3010, "R7", st(m6, 1'b0, 1'b1, m2)); m6 = ~m6; m2 = ~m2;
    endtask

    task automatic t_susp_rd;
        set_mode(3'd3);
        rd(16'h3000, "R8", st(m6, 1'b0, 1'b1, m2)); m2 = ~m2;
        rd(16'h3000, "R3", st(m6, 1'b0, 1'b1, m2)); m2 = ~m2;
        rd(16'h5000, "R8", ARR);
        win = 1'b1;
        rd(16'h3000, "R6", st(m6, 1'b0, 1'b0, m2)); m2 = ~m2;
        win = 1'b0;
    endtask

    task automatic t_susp_pg;
        set_mode(3'd4);
        rd(16'h5000, "R9", st(m6, 1'b0, 1'b1, 1'b1)); m6 = ~m6;
        rd(16'h3000, "R9", st(m6, 1'b0, 1'b1, m2)); m6 = ~m6;
        rd(16'h3000, "R9", st(m6, 1'b0, 1'b1, m2)); m6 = ~m6;
    endtask

    task automatic t_idle;
        set_mode(3'd0);
        arr = 8'h3C;
        rd(16'h3000, "R2", 8'h3C);
        arr = ARR;
    endtask

    task automatic t_prog_timeout;
        set_mode(3'd1);
        pulse = CNT_W'(LIMIT + 1);
        @(negedge clk);
        rd(16'h0200, "R4", st(m6, 1'b1, 1'b0, m2)); m6 = ~m6;
        pulse = '0;
        rd(16'h0200, "R5", st(m6, 1'b1, 1'b0, m2)); m6 = ~m6;
        rd(16'h0200, "R5", st(m6, 1'b1, 1'b0, m2)); m6 = ~m6;
        set_mode(3'd0);
        rd(16'h0200, "R4", ARR);
    endtask

    task automatic t_erase_timeout;
        er_addr = 16'h3000;
        win = 1'b0;
        set_mode(3'd2);
        pulse = CNT_W'(LIMIT + 5);
        @(negedge clk);
        pulse = '0;
        er_addr = 16'h7000;
        rd(16'h3100, "R10", st(m6, 1'b1, 1'b1, m2)); m6 = ~m6; m2 = ~m2;
        rd(16'h7000, "R10", st(m6, 1'b1, 1'b1, m2)); m6 = ~m6;
        rd(16'h3200, "R10", st(m6, 1'b1, 1'b1, m2)); m6 = ~m6; m2 = ~m2;
        rd(16'h3200, "R11", st(m6, 1'b1, 1'b1, m2)); m6 = ~m6; m2 = ~m2;
        set_mode(3'd0);
        rd(16'h3200, "R4", ARR);
    endtask

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #12 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase();
        t_susp_rd();
        t_susp_pg();
        t_idle();
        t_prog_timeout();
        t_erase_timeout();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule